// File: doc/BRIEF.md
# Control Register Bank with Per-Address Write Operators

This block is a bank of 32-bit control and status words behind one write port and one read port. Each address applies its own write operator. The interrupt status word clears the bits written as one. The interrupt mask toggles the bits written as one. Two alias addresses set or clear bits in one shared flag word. One register updates a single bit. One register clears itself on any write. A graphics control word issues a reset strobe. A graphics mode word copies selected bits into a graphics status word. A memory command word drops its busy bit and can zero a device-ID register. Any other address stores the written word unchanged.

Interrupt sources outside the block set status bits through a dedicated set input. The block drives an interrupt line that is high when any status bit is also enabled in the mask. Software reads any word combinationally through the read port.

Top module: `sem_reg_bank`

Word addresses used below: 0 interrupt status, 1 interrupt mask, 2 flag-set alias, 3 flag-clear alias, 4 single-bit control, 5 self-clearing word, 6 graphics control, 7 graphics mode, 8 graphics status, 9 memory command, 10 companion word, 11 device-ID. A write takes effect at the clock edge where `wrEn` is high, and the read port shows the new value from the next cycle.

## Requirements
- R1: The interrupt status word (address 0, IRQ_W bits, zero-extended on read) resets to 0. A write clears every status bit whose data bit is 1 and leaves the other status bits unchanged.
- R2: A bit that is 1 on `irqSet` is set in the status word at that edge. When a software clear and a set hit the same bit in one cycle, the bit ends up 1.
- R3: A write to the mask (address 1, reset 0) XORs data bits [15:0] into the mask. Data bits [31:16] have no effect.
- R4: `irqOut` is 1 exactly when status AND mask is nonzero. It reflects a write to either word in the cycle after the write edge.
- R5: Writing address 2 ORs the data into the flag word. Writing address 3 clears the flag bits whose data bit is 1. Reading either address returns the flag word, which resets to 0.
- R6: The single-bit control word (address 4, reset value BITCTL_INIT, default 0x000000A5) takes only bit 8 from the data. All other bits keep their values.
- R7: The self-clearing word (address 5, reset value ZERO_INIT, default 0x00000F0F) becomes 0 on any write, whatever the data.
- R8: The graphics control word (address 6) stores only data bit 3 and reads 0 in every other bit. When data bit 0 is 1, `gfxRstPulse` is high for exactly the one cycle after the write edge.
- R9: A write to address 6 copies data bit 3 into the pause bit, bit 3 of the graphics status word (address 8).
- R10: The graphics mode word (address 7) stores the full data. The write also copies data bits 0 and 2 into bits 0 and 2 of the graphics status word, and the other status bits keep their values.
- R11: The memory command word (address 9) stores the data with bit 31 forced to 0.
- R12: A command write sets the device-ID word (address 11) to 0 when data[27:16] equals 0x021, data[9:6] equals 1, and bit 7 of the companion word (address 10) is 0. Otherwise the device-ID word is unchanged.
- R13: Every other address, and addresses 8, 10 and 11 when written directly, stores the written word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Word address of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | ADDR_W | Word address of the read |
| rdData | output | 32 | Read data, combinational from rdAddr |
| irqSet | input | IRQ_W | Per-bit interrupt set requests |
| irqOut | output | 1 | Interrupt request, status AND mask nonzero |
| gfxRstPulse | output | 1 | One-cycle graphics reset strobe |

## Verification
A wrong operator shows on the read port in the cycle after the write. Examples are a mask that stores instead of toggling, a clear alias that ORs, or a command word that keeps bit 31. A wrong priority between a set and a software clear leaves a status bit at 0 when it should be 1, and that shows on the next read. Wrong interrupt gating appears on `irqOut` one cycle after the write that changed status or mask. A bad device-ID condition only shows on a later read of address 11, so the bench reads it back right after every qualifying and non-qualifying command write.

// File: rtl/sem_reg_pkg.sv
package sem_reg_pkg;
  localparam int A_STAT    = 0;
  localparam int A_MASK    = 1;
  localparam int A_FSET    = 2;
  localparam int A_FCLR    = 3;
  localparam int A_BITCTL  = 4;
  localparam int A_ZERO    = 5;
  localparam int A_GFXCTL  = 6;
  localparam int A_GFXMODE = 7;
  localparam int A_GFXSTAT = 8;
  localparam int A_CMD     = 9;
  localparam int A_COMP    = 10;
  localparam int A_DEVID   = 11;

  localparam int PAUSE_BIT  = 3;
  localparam int CTL_BIT    = 8;
  localparam int BUSY_BIT   = 31;
  localparam int COMP_BIT   = 7;
  localparam logic [11:0] CMD_OP_MATCH  = 12'h021;
  localparam logic [3:0]  CMD_SUB_MATCH = 4'h1;

  typedef struct packed {
    logic statClr;
    logic maskTgl;
    logic flagOr;
    logic flagAndn;
    logic bitUpd;
    logic zeroWr;
    logic gfxCtlWr;
    logic gfxModeWr;
    logic gfxStatWr;
    logic cmdWr;
    logic compWr;
    logic devIdWr;
    logic plainWr;
    logic devIdRst;
  } strobe_t;
endpackage

// File: rtl/sem_reg_ctrl.sv
module sem_reg_ctrl
  import sem_reg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              compBit,
  output strobe_t           strb
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  logic special;
  logic cmdMatch;

  always_comb begin
    special = hit(wrAddr, A_STAT)   | hit(wrAddr, A_MASK)    | hit(wrAddr, A_FSET) |
              hit(wrAddr, A_FCLR)   | hit(wrAddr, A_BITCTL)  | hit(wrAddr, A_ZERO) |
              hit(wrAddr, A_GFXCTL) | hit(wrAddr, A_GFXMODE) | hit(wrAddr, A_GFXSTAT) |
              hit(wrAddr, A_CMD)    | hit(wrAddr, A_COMP)    | hit(wrAddr, A_DEVID);
    cmdMatch = (wrData[27:16] == CMD_OP_MATCH) && (wrData[9:6] == CMD_SUB_MATCH) && !compBit;

    strb.statClr   = wrEn & hit(wrAddr, A_STAT);
    strb.maskTgl   = wrEn & hit(wrAddr, A_MASK);
    strb.flagOr    = wrEn & hit(wrAddr, A_FSET);
    strb.flagAndn  = wrEn & hit(wrAddr, A_FCLR);
    strb.bitUpd    = wrEn & hit(wrAddr, A_BITCTL);
    strb.zeroWr    = wrEn & hit(wrAddr, A_ZERO);
    strb.gfxCtlWr  = wrEn & hit(wrAddr, A_GFXCTL);
    strb.gfxModeWr = wrEn & hit(wrAddr, A_GFXMODE);
    strb.gfxStatWr = wrEn & hit(wrAddr, A_GFXSTAT);
    strb.cmdWr     = wrEn & hit(wrAddr, A_CMD);
    strb.compWr    = wrEn & hit(wrAddr, A_COMP);
    strb.devIdWr   = wrEn & hit(wrAddr, A_DEVID);
    strb.plainWr   = wrEn & ~special;
    strb.devIdRst  = strb.cmdWr & cmdMatch;
  end

  // R13
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.statClr, strb.maskTgl, strb.flagOr, strb.flagAndn, strb.bitUpd,
              strb.zeroWr, strb.gfxCtlWr, strb.gfxModeWr, strb.gfxStatWr, strb.cmdWr,
              strb.compWr, strb.devIdWr, strb.plainWr}));

  // R12
  devid_rst_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.devIdRst |-> (wrEn && !compBit));
endmodule

// File: rtl/sem_reg_data.sv
module sem_reg_data
  import sem_reg_pkg::*;
#(
  parameter int          ADDR_W      = 5,
  parameter int          IRQ_W       = 16,
  parameter logic [31:0] BITCTL_INIT = 32'h0000_00A5,
  parameter logic [31:0] ZERO_INIT   = 32'h0000_0F0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [IRQ_W-1:0]  irqSet,
  output logic [31:0]       rdData,
  output logic              compBit,
  output logic              irqOut,
  output logic              gfxRstPulse
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [IRQ_W-1:0] irqStat, irqMask;
  logic [31:0] flagWord, bitCtl, zeroReg, gfxCtl, gfxMode, gfxStat;
  logic [31:0] memCmd, compReg, devId;
  logic [31:0] plainMem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqStat     <= '0;
      irqMask     <= '0;
      flagWord    <= '0;
      bitCtl      <= BITCTL_INIT;
      zeroReg     <= ZERO_INIT;
      gfxCtl      <= '0;
      gfxMode     <= '0;
      gfxStat     <= '0;
      memCmd      <= '0;
      compReg     <= '0;
      devId       <= '0;
      gfxRstPulse <= 1'b0;
    end else begin
      irqStat <= (strb.statClr ? (irqStat & ~wrData[IRQ_W-1:0]) : irqStat) | irqSet;
      if (strb.maskTgl)  irqMask  <= irqMask ^ wrData[IRQ_W-1:0];
      if (strb.flagOr)   flagWord <= flagWord | wrData;
      if (strb.flagAndn) flagWord <= flagWord & ~wrData;
      if (strb.bitUpd)   bitCtl[CTL_BIT] <= wrData[CTL_BIT];
      if (strb.zeroWr)   zeroReg <= '0;
      if (strb.gfxCtlWr) gfxCtl  <= wrData & (32'h1 << PAUSE_BIT);
      if (strb.gfxModeWr) gfxMode <= wrData;
      if (strb.gfxStatWr) begin
        gfxStat <= wrData;
      end else begin
        if (strb.gfxCtlWr) gfxStat[PAUSE_BIT] <= wrData[PAUSE_BIT];
        if (strb.gfxModeWr) begin
          gfxStat[0] <= wrData[0];
          gfxStat[2] <= wrData[2];
        end
      end
      if (strb.cmdWr)  memCmd  <= {1'b0, wrData[BUSY_BIT-1:0]};
      if (strb.compWr) compReg <= wrData;
      if (strb.devIdRst)     devId <= '0;
      else if (strb.devIdWr) devId <= wrData;
      gfxRstPulse <= strb.gfxCtlWr & wrData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.plainWr) plainMem[wrAddr] <= wrData;
  end

  assign compBit = compReg[COMP_BIT];
  assign irqOut  = |(irqStat & irqMask);

  always_comb begin
    case (int'(rdAddr))
      A_STAT:    rdData = 32'(irqStat);
      A_MASK:    rdData = 32'(irqMask);
      A_FSET,
      A_FCLR:    rdData = flagWord;
      A_BITCTL:  rdData = bitCtl;
      A_ZERO:    rdData = zeroReg;
      A_GFXCTL:  rdData = gfxCtl;
      A_GFXMODE: rdData = gfxMode;
      A_GFXSTAT: rdData = gfxStat;
      A_CMD:     rdData = memCmd;
      A_COMP:    rdData = compReg;
      A_DEVID:   rdData = devId;
      default:   rdData = plainMem[rdAddr];
    endcase
  end

  // R1
  stat_w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statClr && irqSet == '0) |=> ((irqStat & $past(wrData[IRQ_W-1:0])) == '0));
  // R2
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqSet != '0) |=> ((irqStat & $past(irqSet)) == $past(irqSet)));
  // R7
  zero_on_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.zeroWr |=> (zeroReg == '0));
  // R8
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    gfxRstPulse |-> $past(strb.gfxCtlWr && wrData[0]));
  // R11
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmdWr |=> (memCmd == {1'b0, $past(wrData[30:0])}));
endmodule

// File: rtl/sem_reg_bank.sv
module sem_reg_bank
  import sem_reg_pkg::*;
#(
  parameter int          ADDR_W      = 5,
  parameter int          IRQ_W       = 16,
  parameter logic [31:0] BITCTL_INIT = 32'h0000_00A5,
  parameter logic [31:0] ZERO_INIT   = 32'h0000_0F0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  input  logic [IRQ_W-1:0]  irqSet,
  output logic              irqOut,
  output logic              gfxRstPulse
);
  strobe_t strb;
  logic    compBit;

  sem_reg_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .compBit(compBit), .strb(strb)
  );

  sem_reg_data #(
    .ADDR_W(ADDR_W), .IRQ_W(IRQ_W), .BITCTL_INIT(BITCTL_INIT), .ZERO_INIT(ZERO_INIT)
  ) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .irqSet(irqSet), .rdData(rdData), .compBit(compBit),
    .irqOut(irqOut), .gfxRstPulse(gfxRstPulse)
  );
endmodule

// File: tb/sem_reg_bank_tb_top.sv
`timescale 1ns/1ps
module sem_reg_bank_tb_top;
  localparam int ADDR_W = 5;
  localparam int IRQ_W  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [31:0]       wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [31:0]       rdData;
  logic [IRQ_W-1:0]  irqSet = '0;
  logic              irqOut;
  logic              gfxRstPulse;

  always #4 clk = ~clk;

  sem_reg_bank dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irqSet(irqSet), .irqOut(irqOut),
    .gfxRstPulse(gfxRstPulse)
  );

  typedef struct {
    int          kind;   // 0 read port, 1 irqOut, 2 gfxRstPulse
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int vectors = 0;
  int miscompares = 0;
  logic finished = 1'b0;

  // monitor: pops expectations and compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sbq.pop_front();
        case (it.kind)
          0: act = rdData;
          1: act = 32'(irqOut);
          default: act = 32'(gfxRstPulse);
        endcase
        vectors++;
        if (act !== it.exp) begin
          miscompares++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d, input logic [IRQ_W-1:0] s = '0);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = ADDR_W'(a); wrData = d; irqSet = s;
    @(posedge clk); #1;
    wrEn = 1'b0; irqSet = '0;
  endtask

  task automatic setIrq(input logic [IRQ_W-1:0] s);
    @(posedge clk); #1;
    irqSet = s;
    @(posedge clk); #1;
    irqSet = '0;
  endtask

  task automatic expect_(input int kind, input int a, input logic [31:0] e, input string tag);
    item_t it;
    if (kind == 0) rdAddr = ADDR_W'(a);
    it.kind = kind; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk); #2;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #2;
    // reset state R1 R3 R4 R6 R7 R8 R11
    expect_(0, 0, 32'h0, "R1 status reset");
    expect_(0, 1, 32'h0, "R3 mask reset");
    expect_(1, 0, 32'h0, "R4 irqOut reset");
    expect_(2, 0, 32'h0, "R8 pulse reset");
    expect_(0, 4, 32'h0000_00A5, "R6 bitctl reset");
    expect_(0, 5, 32'h0000_0F0F, "R7 zero reg reset");
    expect_(0, 9, 32'h0, "R11 cmd reset");

    // R2 hardware set
    setIrq(16'h00F0);
    expect_(0, 0, 32'h0000_00F0, "R2 set input");
    expect_(1, 0, 32'h0, "R4 irqOut masked");
    // R3 toggle
    wr(1, 32'h0000_0030);
    expect_(1, 0, 32'h1, "R4 irqOut after mask write");
    expect_(0, 1, 32'h0000_0030, "R3 mask toggle on");
    wr(1, 32'hFFFF_0010);
    expect_(0, 1, 32'h0000_0020, "R3 mask toggle upper ignored");
    // R1 w1c
    wr(0, 32'h0000_0020);
    expect_(0, 0, 32'h0000_00D0, "R1 status w1c");
    expect_(1, 0, 32'h0, "R4 irqOut after clear");
    // R2 set wins against clear
    wr(0, 32'h0000_0081, 16'h0001);
    expect_(0, 0, 32'h0000_0051, "R2 set beats clear");

    // R5 flag aliases
    wr(2, 32'h0000_00F0);
    expect_(0, 2, 32'h0000_00F0, "R5 set alias");
    wr(2, 32'h0000_0F00);
    expect_(0, 3, 32'h0000_0FF0, "R5 read via clear alias");
    wr(3, 32'h0000_0030);
    expect_(0, 2, 32'h0000_0FC0, "R5 clear alias");

    // R6 single bit
    wr(4, 32'hFFFF_FFFF);
    expect_(0, 4, 32'h0000_01A5, "R6 bit8 set only");
    wr(4, 32'h0000_0000);
    expect_(0, 4, 32'h0000_00A5, "R6 bit8 clear only");

    // R7 clear on write
    wr(5, 32'hFFFF_FFFF);
    expect_(0, 5, 32'h0, "R7 clear on write");

    // R13 direct status word write, then R8 R9
    wr(8, 32'hABCD_0000);
    expect_(0, 8, 32'hABCD_0000, "R13 gfx status plain");
    wr(6, 32'h0000_0009);
    expect_(2, 0, 32'h1, "R8 pulse high");
    expect_(2, 0, 32'h0, "R8 pulse one cycle");
    expect_(0, 6, 32'h0000_0008, "R8 ctl keeps bit3 only");
    expect_(0, 8, 32'hABCD_0008, "R9 pause set");
    wr(6, 32'h0000_0008);
    expect_(2, 0, 32'h0, "R8 no pulse without bit0");
    wr(6, 32'h0000_0001);
    expect_(0, 8, 32'hABCD_0000, "R9 pause clear");
    // R10 mode mirror
    wr(7, 32'hFFFF_FFF5);
    expect_(0, 7, 32'hFFFF_FFF5, "R10 mode store");
    expect_(0, 8, 32'hABCD_0005, "R10 mirror bits set");
    wr(7, 32'h0000_0000);
    expect_(0, 8, 32'hABCD_0000, "R10 mirror bits clear");

    // R11 busy bit
    wr(9, 32'hFFFF_FFFF);
    expect_(0, 9, 32'h7FFF_FFFF, "R11 busy forced 0");

    // R12 device id reset
    wr(11, 32'h0000_0055);
    wr(10, 32'h0000_0080);
    wr(9, 32'h0021_0040);
    expect_(0, 11, 32'h0000_0055, "R12 blocked by companion bit7");
    expect_(0, 9, 32'h0021_0040, "R11 cmd store");
    wr(10, 32'h0000_0000);
    wr(9, 32'h8021_0040);
    expect_(0, 11, 32'h0, "R12 device id reset");
    expect_(0, 9, 32'h0021_0040, "R11 busy dropped");
    wr(11, 32'h0000_0066);
    wr(9, 32'h0022_0040);
    expect_(0, 11, 32'h0000_0066, "R12 wrong field no reset");
    wr(9, 32'h0021_0080);
    expect_(0, 11, 32'h0000_0066, "R12 wrong subfield no reset");

    // R13 default storage
    wr(31, 32'h1234_5678);
    expect_(0, 31, 32'h1234_5678, "R13 plain address");
    wr(20, 32'hCAFE_0001);
    expect_(0, 20, 32'hCAFE_0001, "R13 second plain address");
    expect_(0, 31, 32'h1234_5678, "R13 neighbour untouched");

    finished = 1'b1;
    @(negedge clk); #2;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule